// File: doc/BRIEF.md
# Key-Locked Board Control Register Bank

This block is a bank of board-level control and status registers placed in a 4 KB window on a simple 32-bit read/write bus. It returns a fixed identification word and processor identifier. It drives LED outputs and holds two scratch configuration words. It keeps a volatile flag word and a non-volatile flag word, and each flag word has its own set address and clear address. It also keeps a free-running tick counter and reports the live state of two memory-card status lines.

A reset-level register can raise a system reset request. It accepts writes only while a 16-bit lock register holds a magic key. A display-control register has a set of writable bits that depends on a 12-bit board-variant code, taken from bits 27:16 of the identification word. On one variant, the reset-level and display-control registers read as zero and ignore writes. Oscillator, switch, DMA and test offsets are mapped and read as zero. Any offset outside the map, including one with nonzero address bits 1:0, reads as zero, ignores writes and sets a sticky error flag.

A bus access is one cycle with `busSel` high. A write updates state at that clock edge. Read data is registered and is valid in the cycle after the request.

Top module: `sysRegBank`

## Requirements
- R1: After `rstN` is released, `ledOut`, `sysResetReq`, `accessErr`, the lock word, the flags, the configuration words and the reset level are all zero. The display-control word is 0x1F00, except for board code 0x190, where it is zero.
- R2: Writing exactly 0x0000A05F to offset 0x020 stores 0xA05F. Any other value is stored as its bits 14:0 with bit 15 cleared. Offset 0x020 reads the stored 16-bit value.
- R3: A write to offset 0x040 is stored only while the lock word equals 0xA05F. An accepted value with bit 8 set raises `sysResetReq` for exactly the one cycle after the write. Offset 0x040 reads the stored value.
- R4: A write to 0x030 ORs the data into the volatile flags. A write to 0x034 clears each flag bit that is 1 in the data. Offset 0x030 reads the flags.
- R5: A write to 0x038 ORs the data into the non-volatile flags and a write to 0x03C clears them. Offset 0x038 reads them. They are cleared only by `porN` and keep their value through `rstN`.
- R6: Offset 0x000 reads the `BOARD_ID` parameter. When bits 27:16 of that parameter are 0x190, offsets 0x040 and 0x050 read zero and ignore writes.
- R7: For board codes 0x100 and 0x140, a write to 0x050 leaves bits 13:8 unchanged and replaces all other bits. For code 0x100 only, `dispMux` equals bits 1:0 of the display word. For every other code it is 0.
- R8: For board codes 0x178 and 0x182, a write to 0x050 keeps bit 7 and replaces every other bit with the data.
- R9: Offset 0x044 reads 0x00000001, 0x088 reads 0xFF000000 and 0x084 reads the `PROC_ID` parameter. Offset 0x05C reads a 32-bit counter that advances by one on each clock with `tickEn` high.
- R10: Offset 0x048 reads `cardPresent` in bit 0. It reads `writeProtect` in bit 2 for board codes 0x100 and 0x140, and in bit 1 for all other codes.
- R11: An access to an unmapped offset reads zero and changes no register, and it sets `accessErr`. `accessErr` then stays set until `rstN`. Mapped offsets that read as zero, such as 0x00C or 0x0C4, do not set it.
- R12: Offset 0x008 stores the low `LED_W` bits of the write data, drives them on `ledOut` and reads them back. Offsets 0x028 and 0x02C are 32-bit read/write words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Block reset, active low, asynchronous |
| porN | input | 1 | Power-on reset for the non-volatile flags, active low |
| busSel | input | 1 | Bus access request for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read request |
| tickEn | input | 1 | Advances the tick counter |
| cardPresent | input | 1 | Memory card detected |
| writeProtect | input | 1 | Memory card write-protect switch |
| ledOut | output | LED_W | LED drive |
| sysResetReq | output | 1 | One-cycle system reset request |
| dispMux | output | 2 | Display pixel-format select |
| accessErr | output | 1 | Sticky flag for unmapped accesses |

## Verification
A write takes effect at the edge where it is presented. The read data is registered and appears one edge after the read request. The reset request pulse also leaves a register, so it is visible in the cycle after the write and gone one cycle later. `ledOut`, `dispMux` and `accessErr` change at the same edge as the access that causes them. The bench drives each access at a falling edge and samples at the next falling edge, which puts every check exactly one register stage after its stimulus. The pulse check looks at the two falling edges after the write. The tick count is compared after a known number of enabled rising edges, and `tickEn` is held low during the reads around that window.

// File: rtl/sysRegPkg.sv
package sysRegPkg;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ID, SEL_LED, SEL_LOCK, SEL_CFG1, SEL_CFG2, SEL_FLAG,
    SEL_NVFLAG, SEL_RSTLVL, SEL_ONE, SEL_MMC, SEL_DISP, SEL_TICK,
    SEL_PROC, SEL_PROCHI
  } regSel_e;

  typedef struct packed {
    logic    rdEn;
    logic    wrLed;
    logic    wrLock;
    logic    wrCfg1;
    logic    wrCfg2;
    logic    wrFlagSet;
    logic    wrFlagClr;
    logic    wrNvSet;
    logic    wrNvClr;
    logic    wrRstLvl;
    logic    wrDisp;
    logic    badAcc;
    regSel_e sel;
  } strobe_t;

  // Variant on which reset level and display control are absent.
  function automatic logic isBlankVariant(input logic [11:0] code);
    return code == 12'h190;
  endfunction

  function automatic logic dispWritable(input logic [11:0] code);
    return (code == 12'h100) || (code == 12'h140) ||
           (code == 12'h178) || (code == 12'h182);
  endfunction

  // Bits of the display word that a write leaves untouched.
  function automatic logic [31:0] dispKeepMask(input logic [11:0] code);
    if ((code == 12'h100) || (code == 12'h140)) return 32'h0000_3F00;
    if ((code == 12'h178) || (code == 12'h182)) return 32'h0000_0080;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int wpBitPos(input logic [11:0] code);
    return ((code == 12'h100) || (code == 12'h140)) ? 2 : 1;
  endfunction

endpackage

// File: rtl/sysRegCtrl.sv
module sysRegCtrl
  import sysRegPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           st,
  output logic              accessErr
);

  logic    mapped;
  regSel_e sel;
  logic    errQ;

  // Offset decode: mapped flag plus read source.
  always_comb begin
    mapped = 1'b1;
    sel    = SEL_ZERO;
    case (busAddr)
      12'h000: sel = SEL_ID;
      12'h008: sel = SEL_LED;
      12'h020: sel = SEL_LOCK;
      12'h028: sel = SEL_CFG1;
      12'h02C: sel = SEL_CFG2;
      12'h030: sel = SEL_FLAG;
      12'h038: sel = SEL_NVFLAG;
      12'h040: sel = SEL_RSTLVL;
      12'h044: sel = SEL_ONE;
      12'h048: sel = SEL_MMC;
      12'h050: sel = SEL_DISP;
      12'h05C: sel = SEL_TICK;
      12'h084: sel = SEL_PROC;
      12'h088: sel = SEL_PROCHI;
      12'h004, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h024,
      12'h034, 12'h03C, 12'h04C, 12'h054, 12'h058, 12'h060, 12'h064,
      12'h068, 12'h06C, 12'h070, 12'h074, 12'h080, 12'h08C, 12'h090,
      12'h094, 12'h098, 12'h09C, 12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC,
      12'h0D0: sel = SEL_ZERO;
      default: mapped = 1'b0;
    endcase
  end

  always_comb begin
    logic wr;
    wr           = busSel && busWr;
    st           = '0;
    st.sel       = sel;
    st.rdEn      = busSel && !busWr;
    st.badAcc    = busSel && !mapped;
    st.wrLed     = wr && (busAddr == 12'h008);
    st.wrLock    = wr && (busAddr == 12'h020);
    st.wrCfg1    = wr && (busAddr == 12'h028);
    st.wrCfg2    = wr && (busAddr == 12'h02C);
    st.wrFlagSet = wr && (busAddr == 12'h030);
    st.wrFlagClr = wr && (busAddr == 12'h034);
    st.wrNvSet   = wr && (busAddr == 12'h038);
    st.wrNvClr   = wr && (busAddr == 12'h03C);
    st.wrRstLvl  = wr && (busAddr == 12'h040);
    st.wrDisp    = wr && (busAddr == 12'h050);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errQ <= 1'b0;
    else if (st.badAcc) errQ <= 1'b1;
  end

  assign accessErr = errQ;

endmodule

// File: rtl/sysRegData.sv
module sysRegData
  import sysRegPkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          LED_W     = 8,
  parameter logic [31:0] BOARD_ID  = 32'h1100_0A5A,
  parameter logic [31:0] PROC_ID   = 32'h0200_0000,
  parameter logic [15:0] LOCK_KEY  = 16'hA05F,
  parameter int          RQ_BIT    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tickEn,
  input  logic              cardPresent,
  input  logic              writeProtect,
  output logic [DATA_W-1:0] rdata,
  output logic [LED_W-1:0]  ledOut,
  output logic              sysResetReq,
  output logic [1:0]        dispMux
);

  localparam logic [11:0]       BOARD_CODE = BOARD_ID[27:16];
  localparam logic              BLANK      = isBlankVariant(BOARD_CODE);
  localparam logic              DISP_WR    = dispWritable(BOARD_CODE) && !BLANK;
  localparam logic [DATA_W-1:0] KEEP       = dispKeepMask(BOARD_CODE);
  localparam logic [DATA_W-1:0] DISP_RST   = BLANK ? '0 : 32'h0000_1F00;
  localparam int                WP_POS     = wpBitPos(BOARD_CODE);

  logic [LED_W-1:0]  ledReg;
  logic [15:0]       lockReg;
  logic [DATA_W-1:0] cfgA, cfgB, flagReg, nvReg, rstLvl, dispReg, tickCnt;
  logic [DATA_W-1:0] mmcWord, rdNext;
  logic              lockOpen, rqQ;

  assign lockOpen = (lockReg == LOCK_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledReg  <= '0;
      lockReg <= '0;
      cfgA    <= '0;
      cfgB    <= '0;
      flagReg <= '0;
      rstLvl  <= '0;
      dispReg <= DISP_RST;
      tickCnt <= '0;
      rqQ     <= 1'b0;
    end else begin
      rqQ <= 1'b0;
      if (st.wrLed)  ledReg <= wdata[LED_W-1:0];
      if (st.wrLock) lockReg <= (wdata == {16'h0000, LOCK_KEY}) ? LOCK_KEY
                                                               : {1'b0, wdata[14:0]};
      if (st.wrCfg1) cfgA <= wdata;
      if (st.wrCfg2) cfgB <= wdata;
      if (st.wrFlagSet)      flagReg <= flagReg | wdata;
      else if (st.wrFlagClr) flagReg <= flagReg & ~wdata;
      if (st.wrRstLvl && lockOpen && !BLANK) begin
        rstLvl <= wdata;
        rqQ    <= wdata[RQ_BIT];
      end
      if (st.wrDisp && DISP_WR) dispReg <= (dispReg & KEEP) | (wdata & ~KEEP);
      if (tickEn) tickCnt <= tickCnt + 1'b1;
    end
  end

  // Non-volatile flags follow only the power-on reset.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)             nvReg <= '0;
    else if (st.wrNvSet)   nvReg <= nvReg | wdata;
    else if (st.wrNvClr)   nvReg <= nvReg & ~wdata;
  end

  always_comb begin
    mmcWord         = '0;
    mmcWord[0]      = cardPresent;
    mmcWord[WP_POS] = writeProtect;
  end

  always_comb begin
    case (st.sel)
      SEL_ID:     rdNext = BOARD_ID;
      SEL_LED:    rdNext = {{(DATA_W-LED_W){1'b0}}, ledReg};
      SEL_LOCK:   rdNext = {16'h0000, lockReg};
      SEL_CFG1:   rdNext = cfgA;
      SEL_CFG2:   rdNext = cfgB;
      SEL_FLAG:   rdNext = flagReg;
      SEL_NVFLAG: rdNext = nvReg;
      SEL_RSTLVL: rdNext = BLANK ? '0 : rstLvl;
      SEL_ONE:    rdNext = 32'h0000_0001;
      SEL_MMC:    rdNext = mmcWord;
      SEL_DISP:   rdNext = dispReg;
      SEL_TICK:   rdNext = tickCnt;
      SEL_PROC:   rdNext = PROC_ID;
      SEL_PROCHI: rdNext = 32'hFF00_0000;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdata <= '0;
    else if (st.rdEn) rdata <= rdNext;
    else              rdata <= '0;
  end

  generate
    if (BOARD_CODE == 12'h100) begin : g_mux
      assign dispMux = dispReg[1:0];
    end else begin : g_noMux
      assign dispMux = 2'b00;
    end
  endgenerate

  assign ledOut      = ledReg;
  assign sysResetReq = rqQ;

endmodule

// File: rtl/sysRegBank.sv
module sysRegBank
  import sysRegPkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          LED_W    = 8,
  parameter logic [31:0] BOARD_ID = 32'h1100_0A5A,
  parameter logic [31:0] PROC_ID  = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  input  logic              cardPresent,
  input  logic              writeProtect,
  output logic [LED_W-1:0]  ledOut,
  output logic              sysResetReq,
  output logic [1:0]        dispMux,
  output logic              accessErr
);

  strobe_t st;

  sysRegCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .st(st), .accessErr(accessErr)
  );

  sysRegData #(
    .DATA_W(DATA_W), .LED_W(LED_W), .BOARD_ID(BOARD_ID), .PROC_ID(PROC_ID)
  ) data_i (
    .clk(clk), .rstN(rstN), .porN(porN), .st(st), .wdata(busWdata),
    .tickEn(tickEn), .cardPresent(cardPresent), .writeProtect(writeProtect),
    .rdata(busRdata), .ledOut(ledOut), .sysResetReq(sysResetReq),
    .dispMux(dispMux)
  );

endmodule

// File: rtl/sysRegChk.sv
module sysRegChk #(
  parameter int LED_W = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [11:0] busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [LED_W-1:0] ledOut,
  input logic        sysResetReq,
  input logic [1:0]  dispMux,
  input logic        accessErr
);

  // R3
  reset_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(busSel && busWr && busAddr == 12'h040 && busWdata[8]));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |=> accessErr);

  // R12
  led_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr && busAddr == 12'h008) |=> $stable(ledOut));

  // R7
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr && busAddr == 12'h050) |=> $stable(dispMux));

  // R9
  const_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 12'h044) |=> busRdata == 32'h1);

  // R9
  const_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 12'h088) |=> busRdata == 32'hFF00_0000);

endmodule

bind sysRegBank sysRegChk #(.LED_W(LED_W)) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .ledOut(ledOut),
  .sysResetReq(sysResetReq), .dispMux(dispMux), .accessErr(accessErr)
);

// File: tb/sysRegBank_tb_top.sv
module sysRegBank_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0, porN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic tickEn = 1'b0, cardPresent = 1'b0, writeProtect = 1'b0;
  logic [31:0] rdA, rdV, rdP;
  logic [7:0]  ledA, ledV, ledP;
  logic rqA, rqV, rqP, errA, errV, errP;
  logic [1:0] muxA, muxV, muxP;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysRegBank #(.BOARD_ID(32'h1100_0A5A)) dut_i (
    .clk(clk), .rstN(rstN), .porN(porN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdA), .tickEn(tickEn),
    .cardPresent(cardPresent), .writeProtect(writeProtect), .ledOut(ledA),
    .sysResetReq(rqA), .dispMux(muxA), .accessErr(errA));

  sysRegBank #(.BOARD_ID(32'h0190_0000)) dutVx_i (
    .clk(clk), .rstN(rstN), .porN(porN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdV), .tickEn(tickEn),
    .cardPresent(cardPresent), .writeProtect(writeProtect), .ledOut(ledV),
    .sysResetReq(rqV), .dispMux(muxV), .accessErr(errV));

  sysRegBank #(.BOARD_ID(32'h0182_0000)) dutPb_i (
    .clk(clk), .rstN(rstN), .porN(porN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdP), .tickEn(tickEn),
    .cardPresent(cardPresent), .writeProtect(writeProtect), .ledOut(ledP),
    .sysResetReq(rqP), .dispMux(muxP), .accessErr(errP));

  // {req, wr, addr, wdata, expected read of dut_i}
  localparam int NV = 35;
  localparam logic [84:0] VEC [NV] = '{
    {8'd6,  1'b0, 12'h000, 32'h0,         32'h1100_0A5A}, // R6
    {8'd9,  1'b0, 12'h084, 32'h0,         32'h0200_0000}, // R9
    {8'd9,  1'b0, 12'h044, 32'h0,         32'h0000_0001}, // R9
    {8'd9,  1'b0, 12'h088, 32'h0,         32'hFF00_0000}, // R9
    {8'd12, 1'b1, 12'h008, 32'hA5,        32'h0},         // R12
    {8'd12, 1'b0, 12'h008, 32'h0,         32'hA5},
    {8'd12, 1'b1, 12'h008, 32'h1FF,       32'h0},
    {8'd12, 1'b0, 12'h008, 32'h0,         32'hFF},
    {8'd12, 1'b1, 12'h028, 32'hDEADBEEF,  32'h0},
    {8'd12, 1'b0, 12'h028, 32'h0,         32'hDEADBEEF},
    {8'd12, 1'b1, 12'h02C, 32'h12345678,  32'h0},
    {8'd12, 1'b0, 12'h02C, 32'h0,         32'h12345678},
    {8'd4,  1'b1, 12'h030, 32'hF0,        32'h0},         // R4
    {8'd4,  1'b1, 12'h030, 32'h0F,        32'h0},
    {8'd4,  1'b0, 12'h030, 32'h0,         32'hFF},
    {8'd4,  1'b1, 12'h034, 32'h3C,        32'h0},
    {8'd4,  1'b0, 12'h030, 32'h0,         32'hC3},
    {8'd5,  1'b1, 12'h038, 32'h11,        32'h0},         // R5
    {8'd5,  1'b1, 12'h03C, 32'h01,        32'h0},
    {8'd5,  1'b0, 12'h038, 32'h0,         32'h10},
    {8'd2,  1'b1, 12'h020, 32'h1234,      32'h0},         // R2
    {8'd2,  1'b0, 12'h020, 32'h0,         32'h1234},
    {8'd2,  1'b1, 12'h020, 32'hFFFF,      32'h0},
    {8'd2,  1'b0, 12'h020, 32'h0,         32'h7FFF},
    {8'd3,  1'b1, 12'h040, 32'h55,        32'h0},         // R3 locked
    {8'd3,  1'b0, 12'h040, 32'h0,         32'h0},
    {8'd2,  1'b1, 12'h020, 32'hA05F,      32'h0},
    {8'd2,  1'b0, 12'h020, 32'h0,         32'hA05F},
    {8'd3,  1'b1, 12'h040, 32'hFF,        32'h0},         // R3 unlocked
    {8'd3,  1'b0, 12'h040, 32'h0,         32'hFF},
    {8'd7,  1'b0, 12'h050, 32'h0,         32'h1F00},      // R7
    {8'd7,  1'b1, 12'h050, 32'hFFFFFFFF,  32'h0},
    {8'd7,  1'b0, 12'h050, 32'h0,         32'hFFFFDFFF},
    {8'd11, 1'b0, 12'h00C, 32'h0,         32'h0},         // R11
    {8'd11, 1'b0, 12'h0C4, 32'h0,         32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic blockReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [31:0] t0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ledOut", {24'h0, ledA}, 32'h0);
    check("R1 sysResetReq", {31'h0, rqA}, 32'h0);
    check("R1 accessErr", {31'h0, errA}, 32'h0);
    rd(12'h050); check("R1 disp dutVx", rdV, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64]);
        checks++;
        if (rdA !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h",
                   VEC[i][84:77], i, rdA, VEC[i][31:0]);
        end
      end
    end

    check("R12 ledOut", {24'h0, ledA}, 32'hFF);
    check("R7 dispMux code 0x100", {30'h0, muxA}, 32'h3);
    check("R7 dispMux code 0x190", {30'h0, muxV}, 32'h0);
    rd(12'h050);
    check("R8 disp code 0x182", rdP, 32'hFFFFFF7F);
    check("R6 disp code 0x190", rdV, 32'h0);
    rd(12'h040);
    check("R6 rstlvl code 0x190", rdV, 32'h0);
    wr(12'h050, 32'h0);
    rd(12'h050);
    check("R8 disp code 0x182 second", rdP, 32'h0);
    check("R7 disp code 0x100 second", rdA, 32'h1F00);
    check("R11 no error yet", {31'h0, errA}, 32'h0);

    // R3 pulse timing
    wr(12'h040, 32'h100);
    check("R3 pulse cycle", {31'h0, rqA}, 32'h1);
    check("R6 no pulse code 0x190", {31'h0, rqV}, 32'h0);
    @(negedge clk);
    check("R3 pulse ends", {31'h0, rqA}, 32'h0);
    rd(12'h040); check("R3 level", rdA, 32'h100);
    wr(12'h020, 32'h0);
    wr(12'h040, 32'h1FF);
    check("R3 locked no pulse", {31'h0, rqA}, 32'h0);
    rd(12'h040); check("R3 locked ignored", rdA, 32'h100);

    // R10 card lines
    cardPresent = 1'b1; writeProtect = 1'b1;
    rd(12'h048);
    check("R10 code 0x100", rdA, 32'h5);
    check("R10 code 0x190", rdV, 32'h3);
    check("R10 code 0x182", rdP, 32'h3);
    cardPresent = 1'b0;
    rd(12'h048); check("R10 wp only", rdA, 32'h4);

    // R9 tick counter
    rd(12'h05C); t0 = rdA;
    @(negedge clk); tickEn = 1'b1;
    repeat (37) @(negedge clk);
    tickEn = 1'b0;
    rd(12'h05C); check("R9 tick advance", rdA, t0 + 32'd37);

    // R11 unmapped
    rd(12'h0FC); check("R11 read zero", rdA, 32'h0);
    check("R11 err set", {31'h0, errA}, 32'h1);
    wr(12'h0A0, 32'h55); rd(12'h0A0); check("R11 write ignored", rdA, 32'h0);
    wr(12'h009, 32'h0); rd(12'h008); check("R11 unaligned ignored", rdA, 32'hFF);
    check("R11 err sticky", {31'h0, errA}, 32'h1);

    // R1 / R5 block reset
    blockReset();
    @(negedge clk);
    check("R1 ledOut after reset", {24'h0, ledA}, 32'h0);
    check("R1 err after reset", {31'h0, errA}, 32'h0);
    rd(12'h038); check("R5 nv survives", rdA, 32'h10);
    rd(12'h030); check("R1 flags", rdA, 32'h0);
    rd(12'h020); check("R1 lock", rdA, 32'h0);
    rd(12'h040); check("R1 rstlvl", rdA, 32'h0);
    rd(12'h028); check("R1 cfg", rdA, 32'h0);
    rd(12'h050); check("R1 disp", rdA, 32'h1F00);
    @(negedge clk); porN = 1'b0;
    @(negedge clk); porN = 1'b1;
    rd(12'h038); check("R5 por clears", rdA, 32'h0);

    finishRun();
  end

endmodule